// File: doc/BRIEF.md
# Three-Lane DC-Balance Word Deserializer

This block turns three serial lanes, sampled on an ideal bit clock, into one 21-bit parallel word. A word-boundary marker, asserted with the last bit of every word, frames the lanes. Nothing is counted inside the block: each lane keeps a short shift history, and the marker says when that history holds a complete group.

Two framings are supported and picked by a mode input. In plain framing each lane sends seven data bits per word. In balanced framing each lane sends nine bits. These are seven data bits followed by a pair of complementary flag bits. The flag pair tells the receiver whether the transmitter inverted the group to keep the line's running disparity bounded. The block restores the original data and reports flag pairs that are not legal codes. The decoded word comes out with a one-cycle valid pulse. A strobe follows one cycle later, and its active edge (rising or falling) is chosen by a configuration input.

Top module: `dcb_deser_top`

## Requirements
- R1: In plain framing (bal_mode = 0) each lane sends 7 bits per word, data bit 0 first. Lane L drives par_out bits 7L to 7L+6, with data bit k landing on par_out[7L+k].
- R2: In balanced framing (bal_mode = 1) each lane sends 9 bits per word: data bits 0 to 6 in that order, then flag bit A, then flag bit B. The pair is read as {A,B}. Pair 2'b01 means the data was sent true, and the seven bits are output as received.
- R3: In balanced framing, pair 2'b10 means the data was sent inverted, and the block outputs the complement of the seven received bits.
- R4: In balanced framing, pair 2'b00 or 2'b11 sets code_err bit L for lane L, and that lane's seven bits are output as received. A legal pair clears the lane's code_err bit.
- R5: In plain framing no flag bits are expected and none are decoded. A word decoded in plain framing always reports code_err = 3'b000.
- R6: par_out, code_err and par_valid update on the clock edge that samples word_end high. par_valid is high for that one cycle only. Between updates, par_out and code_err hold their values.
- R7: strb_out equals an internal active level XOR strobe_fall. The active level is high for exactly the one cycle after the par_valid pulse. So with strobe_fall = 0 the strobe's rising edge marks stable data, and with strobe_fall = 1 its falling edge does.
- R8: bal_mode is sampled only in the cycle where word_end is high. If the sampled value differs from the current framing, the word ending there is still decoded in the old framing. The next word, the first one in the new framing, is discarded: it gives no valid pulse and no strobe, and the outputs hold.
- R9: During and after reset, par_out and code_err are zero, par_valid is low and strb_out is inactive (equal to strobe_fall). The framing is plain. The first word completed after reset only establishes framing and is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Ideal serial bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_in | input | 3 | One serial bit per lane per clock, lane L on bit L |
| word_end | input | 1 | High with the final bit of each word |
| bal_mode | input | 1 | 1 selects balanced 9-bit framing, 0 selects plain 7-bit framing |
| strobe_fall | input | 1 | 0 gives a rising-edge strobe, 1 gives a falling-edge strobe |
| par_out | output | 21 | Decoded parallel word |
| code_err | output | 3 | Per-lane illegal flag pair indication |
| par_valid | output | 1 | One-cycle pulse when par_out and code_err take a new word |
| strb_out | output | 1 | Output strobe with configurable active edge |

## Verification
A framing change and a word decode can fall on the same boundary cycle. The word that closes on that boundary must be decoded in the old framing while the new framing is latched, and the following word must be dropped. The bench provokes this by raising or lowering bal_mode only on the last bit of a word sent in the old format. It judges the result by checking for a valid decode of that word, then checking that the next word gives no pulse, no strobe and unchanged outputs. It also toggles bal_mode on non-final bits to show that only the boundary sample counts. Every combination of flag pairs on the three lanes is swept in balanced framing under both strobe polarities.

// File: rtl/dcb_pkg.sv
package dcb_pkg;
    localparam int FLAG_W = 2;

    typedef enum logic [1:0] {
        FLAG_ZERO = 2'b00,
        FLAG_TRUE = 2'b01,
        FLAG_INV  = 2'b10,
        FLAG_ONES = 2'b11
    } flag_e;
endpackage

// File: rtl/dcb_lane_shifter.sv
module dcb_lane_shifter #(
    parameter int GRP_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_i,
    output logic [GRP_W-1:0] grp_o
);
    localparam int HIST_W = GRP_W - 1;

    logic [HIST_W-1:0] hist_d;
    logic [HIST_W-1:0] hist_q;

    // newest bit sits at the top; the oldest of the group at bit 0
    always_comb begin
        hist_d = {bit_i, hist_q[HIST_W-1:1]};
        grp_o  = {bit_i, hist_q};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= hist_d;
    end
endmodule

// File: rtl/dcb_lane_decode.sv
module dcb_lane_decode
    import dcb_pkg::*;
#(
    parameter int DATA_W = 7
) (
    input  logic [DATA_W+FLAG_W-1:0] grp_i,
    input  logic                     bal_i,
    output logic [DATA_W-1:0]        data_o,
    output logic                     err_o
);
    flag_e pair;

    always_comb begin
        // first flag bit sent forms the pair MSB
        pair   = flag_e'({grp_i[DATA_W], grp_i[DATA_W+1]});
        data_o = grp_i[DATA_W+FLAG_W-1:FLAG_W];
        err_o  = 1'b0;
        if (bal_i) begin
            data_o = grp_i[DATA_W-1:0];
            case (pair)
                FLAG_INV:  data_o = ~grp_i[DATA_W-1:0];
                FLAG_TRUE: data_o = grp_i[DATA_W-1:0];
                default:   err_o  = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/dcb_frame_ctrl.sv
module dcb_frame_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic word_end_i,
    input  logic bal_pin_i,
    output logic bal_o,
    output logic accept_o
);
    typedef struct packed {
        logic bal;
        logic skip;
    } ctrl_s;

    ctrl_s st_d;
    ctrl_s st_q;

    always_comb begin
        st_d     = st_q;
        accept_o = word_end_i && !st_q.skip;
        if (word_end_i) begin
            st_d.skip = (bal_pin_i != st_q.bal);
            st_d.bal  = bal_pin_i;
        end
        bal_o = st_q.bal;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.bal  <= 1'b0;
            st_q.skip <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/dcb_deser_top.sv
module dcb_deser_top
    import dcb_pkg::*;
#(
    parameter int LANES  = 3,
    parameter int DATA_W = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES-1:0]        ser_in,
    input  logic                    word_end,
    input  logic                    bal_mode,
    input  logic                    strobe_fall,
    output logic [LANES*DATA_W-1:0] par_out,
    output logic [LANES-1:0]        code_err,
    output logic                    par_valid,
    output logic                    strb_out
);
    localparam int GRP_W = DATA_W + FLAG_W;
    localparam int BUS_W = LANES * DATA_W;

    typedef struct packed {
        logic [BUS_W-1:0] par;
        logic [LANES-1:0] err;
        logic             valid;
        logic             strb;
    } out_s;

    out_s             o_d;
    out_s             o_q;
    logic             cur_mode;
    logic             accept;
    logic [BUS_W-1:0] dec_word;
    logic [LANES-1:0] dec_err;

    dcb_frame_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_end_i (word_end),
        .bal_pin_i  (bal_mode),
        .bal_o      (cur_mode),
        .accept_o   (accept)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [GRP_W-1:0] grp;

        dcb_lane_shifter #(.GRP_W(GRP_W)) u_shift (
            .clk   (clk),
            .rst_n (rst_n),
            .bit_i (ser_in[l]),
            .grp_o (grp)
        );

        dcb_lane_decode #(.DATA_W(DATA_W)) u_dec (
            .grp_i  (grp),
            .bal_i  (cur_mode),
            .data_o (dec_word[l*DATA_W +: DATA_W]),
            .err_o  (dec_err[l])
        );
    end

    always_comb begin
        o_d       = o_q;
        o_d.valid = accept;
        o_d.strb  = o_q.valid;
        if (accept) begin
            o_d.par = dec_word;
            o_d.err = dec_err;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign par_out   = o_q.par;
    assign code_err  = o_q.err;
    assign par_valid = o_q.valid;
    assign strb_out  = o_q.strb ^ strobe_fall;
endmodule

// File: rtl/dcb_deser_chk.sv
module dcb_deser_chk #(
    parameter int LANES = 3,
    parameter int BUS_W = 21
) (
    input logic             clk,
    input logic             rst_n,
    input logic             word_end,
    input logic             strobe_fall,
    input logic             cur_mode,
    input logic [BUS_W-1:0] par_out,
    input logic [LANES-1:0] code_err,
    input logic             par_valid,
    input logic             strb_out
);
    p_valid_at_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
        par_valid |-> $past(word_end));

    p_hold_between_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !par_valid |-> ($stable(par_out) && $stable(code_err)));

    p_strobe_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_out ^ strobe_fall) == $past(par_valid));

    p_plain_no_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (par_valid && !$past(cur_mode)) |-> (code_err == '0));
endmodule

bind dcb_deser_top dcb_deser_chk #(.LANES(LANES), .BUS_W(BUS_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .word_end    (word_end),
    .strobe_fall (strobe_fall),
    .cur_mode    (cur_mode),
    .par_out     (par_out),
    .code_err    (code_err),
    .par_valid   (par_valid),
    .strb_out    (strb_out)
);

// File: tb/test_dcb_deser_top.sv
module test_dcb_deser_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  ser_in = '0;
    logic        word_end = 1'b0;
    logic        bal_mode = 1'b0;
    logic        strobe_fall = 1'b0;
    logic [20:0] par_out;
    logic [2:0]  code_err;
    logic        par_valid;
    logic        strb_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic        m_mode = 1'b0;
    logic        m_skip = 1'b1;
    logic [20:0] e_par = '0;
    logic [2:0]  e_err = '0;

    always #2 clk = ~clk;

    dcb_deser_top i_dcb_deser_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .ser_in      (ser_in),
        .word_end    (word_end),
        .bal_mode    (bal_mode),
        .strobe_fall (strobe_fall),
        .par_out     (par_out),
        .code_err    (code_err),
        .par_valid   (par_valid),
        .strb_out    (strb_out)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic send_word(input logic pin, input logic glitch, input logic [20:0] d, input logic [5:0] fl);
        logic [8:0] grp [3];
        logic [2:0] werr;
        logic       exp_v;
        int         n;
        int         off;
        exp_v = !m_skip;
        werr  = '0;
        n     = m_mode ? 9 : 7;
        off   = m_mode ? 0 : 2;
        for (int l = 0; l < 3; l++) begin
            logic [6:0] dl;
            logic [1:0] pr;
            dl = d[7*l +: 7];
            pr = fl[2*l +: 2];
            if (m_mode) begin
                grp[l] = {pr[0], pr[1], (pr == 2'b10) ? ~dl : dl};
                werr[l] = (pr == 2'b00) || (pr == 2'b11);
            end else begin
                grp[l] = {dl, 2'b00};
            end
        end
        for (int b = 0; b < n; b++) begin
            @(negedge clk);
            for (int l = 0; l < 3; l++) ser_in[l] = grp[l][off + b];
            word_end = (b == n - 1);
            bal_mode = (b == n - 1) ? pin : (glitch ? ~pin : pin);
        end
        @(posedge clk);
        #1;
        if (exp_v) begin
            chk(par_valid == 1'b1, "R6 valid pulse", 32'(par_valid), 32'd1);
            chk(par_out == d, m_mode ? "R2/R3 balanced data" : "R1 plain data", 32'(par_out), 32'(d));
            chk(code_err == werr, m_mode ? "R4 code error" : "R5 no error in plain", 32'(code_err), 32'(werr));
            e_par = d;
            e_err = werr;
        end else begin
            chk(par_valid == 1'b0, "R8/R9 discarded word valid", 32'(par_valid), 32'd0);
            chk(par_out == e_par, "R8/R9 discarded word holds data", 32'(par_out), 32'(e_par));
            chk(code_err == e_err, "R8/R9 discarded word holds error", 32'(code_err), 32'(e_err));
        end
        m_skip = (pin != m_mode);
        m_mode = pin;
        @(negedge clk);
        word_end = 1'b0;
        bal_mode = pin;
        @(posedge clk);
        #1;
        chk(par_valid == 1'b0, "R6 valid single cycle", 32'(par_valid), 32'd0);
        chk((strb_out ^ strobe_fall) == exp_v, "R7 strobe active level", 32'(strb_out), 32'(exp_v ^ strobe_fall));
    endtask

    initial begin
        #800000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        #1;
        chk(par_out == '0, "R9 reset data", 32'(par_out), 32'd0);
        chk(code_err == '0, "R9 reset error", 32'(code_err), 32'd0);
        chk(par_valid == 1'b0, "R9 reset valid", 32'(par_valid), 32'd0);
        chk(strb_out == strobe_fall, "R9 reset strobe", 32'(strb_out), 32'(strobe_fall));
        @(negedge clk);
        rst_n = 1'b1;

        // R9: first word only frames
        send_word(1'b0, 1'b0, 21'h1ABCDE, 6'h00);
        // R1: walking ones and mixed patterns in plain framing
        for (int i = 0; i < 21; i++) send_word(1'b0, 1'b0, 21'(1) << i, 6'h00);
        for (int i = 0; i < 8; i++) send_word(1'b0, (i % 2) == 1, 21'((i * 32'h0B5A3 + 32'h12345)), 6'(i * 11));
        // R8: switch to balanced on the boundary of a plain word
        send_word(1'b1, 1'b0, 21'h0F0F0F, 6'h00);
        send_word(1'b1, 1'b0, 21'h155555, 6'h15);
        // R2/R3/R4: every flag pair combination across the lanes
        for (int c = 0; c < 64; c++) begin
            if (c == 32) strobe_fall = 1'b1;
            send_word(1'b1, (c % 5) == 0, 21'((c * 32'h0D3A7 + 32'h2468A)), 6'(c));
        end
        // R8: switch back to plain on the boundary of a balanced word
        send_word(1'b0, 1'b0, 21'h1C3A5F, 6'h26);
        send_word(1'b0, 1'b0, 21'h000777, 6'h00);
        for (int i = 0; i < 6; i++) send_word(1'b0, 1'b1, 21'h1FFFFF >> i, 6'h3F);
        strobe_fall = 1'b0;
        send_word(1'b0, 1'b0, 21'h0A5A5A, 6'h00);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule